// File: doc/BRIEF.md
# Mood-State Instruction Sequencer

This block is a toy sequencer that takes a stream of 4-bit opcodes and, instead of computing, tracks four 2-bit mood registers: sleep, talk, drink and affection. Each accepted opcode may change those registers, emit a 3-bit output code with a one-cycle valid flag, or steer how later opcodes are handled. The opcodes that steer later handling are repeat, dice and interpret.

A 16-bit LFSR supplies the randomness for three opcodes. Repeat re-executes the last executed opcode a random number of times within one cycle. Dice may skip the next opcode. Interpret swaps the next opcode for one the block chooses itself. A halt opcode sets a sticky death flag. While that flag is set, only the revive opcode gets through.

All results are registered. An opcode presented at clock edge N shows its effect on the outputs after edge N. The reset is synchronous and active high.

Top module: `mood_seq`

## Requirements
- R1: After reset, sleep=2 (asleep), talk=3 (listening), drink=2 (normal), affection=2 (neutral), dead=0, pc=0, out_valid=0 and out_code=0.
- R2: Opcode values are 0 birth, 1 halt, 2 revive, 3 idle, 4 repeat, 5 dice, 6 drink, 7 ponder, 8 hesitate, 9 interpret, 10 lie, 11 cry, 12 joke, 13 nap, 14 fall-in-love, 15 intimacy. Output codes are 0 beg, 1 mutter, 2 snore, 3 babble, 4 flirt, 5 desire, 6 invent, 7 itch.
- R3: Birth sets sleep=0 (awake). Cry sets talk=0 (screaming). Joke sets talk=1 (laughing). Lie sets talk=2 (whistling). Nap raises sleep by one step while it is below 2 and otherwise leaves it unchanged. All of these results appear in the cycle after the opcode is accepted.
- R4: Drink lowers the drink state by one step toward 0 (drunk) and stays at 0 once there. Fall-in-love sets affection=1 (excited). Intimacy sets affection=0 (eager). The emitted codes are: drink babble, ponder invent, hesitate mutter, lie itch, nap snore, fall-in-love flirt, intimacy desire, revive beg. out_valid is high for exactly one cycle after such an opcode. After any other opcode, and while out_valid is low, out_code is 0.
- R5: Halt sets dead. While dead, every opcode except revive is ignored: no change to the mood registers, pc or outputs. Revive clears dead.
- R6: Idle changes no mood register and emits nothing, but pc still advances.
- R7: pc increments by one, with wrap-around, for every accepted opcode. An accepted opcode is one with op_valid high that is not blocked by death. Skipped opcodes count as accepted.
- R8: The LFSR seeds to 0xACE1 and advances once per accepted opcode as x <= {x[14:0], x[15]^x[13]^x[12]^x[10]}. Every random decision uses the value held before that advance.
- R9: Repeat applies the last executed non-control opcode (x[1:0]+1) times in one step and emits that opcode's code. It does not change which opcode counts as last. After reset, the last opcode is idle.
- R10: Dice with x[0]=1 makes the next accepted opcode a skip: pc advances, but there is no effect and no output. Dice with x[0]=0 has no effect on the next opcode.
- R11: Interpret replaces the next accepted opcode with x[3:0]. If x[3:0] is repeat, dice or interpret, idle is used instead.
- R12: With op_valid low, nothing changes and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Opcode |
| op_valid | input | 1 | Opcode strobe |
| st_sleep | output | 2 | Sleep mood |
| st_talk | output | 2 | Talk mood |
| st_drink | output | 2 | Drink mood |
| st_affect | output | 2 | Affection mood |
| out_code | output | 3 | Emitted output code |
| out_valid | output | 1 | out_code valid for one cycle |
| dead | output | 1 | Sticky death flag |
| pc | output | PC_W | Program counter |

## Verification
The hardest situations to reach are the ones where the random source decides: a dice that really skips, an interpret that lands on halt, and a repeat with the full count of four applied to a saturating opcode. The bench therefore carries its own LFSR model, in step with every accepted opcode. It issues long runs of dice/cry and interpret/opcode pairs until both skip outcomes and many substitutions have occurred, and it sets up repeats after drink and nap so that their saturation points are crossed.

// File: rtl/mood_pkg.sv
`timescale 1ns/1ps
package mood_pkg;
  localparam logic [3:0] OP_BIRTH     = 4'd0;
  localparam logic [3:0] OP_HALT      = 4'd1;
  localparam logic [3:0] OP_REVIVE    = 4'd2;
  localparam logic [3:0] OP_IDLE      = 4'd3;
  localparam logic [3:0] OP_REPEAT    = 4'd4;
  localparam logic [3:0] OP_DICE      = 4'd5;
  localparam logic [3:0] OP_DRINK     = 4'd6;
  localparam logic [3:0] OP_PONDER    = 4'd7;
  localparam logic [3:0] OP_HESITATE  = 4'd8;
  localparam logic [3:0] OP_INTERPRET = 4'd9;
  localparam logic [3:0] OP_LIE       = 4'd10;
  localparam logic [3:0] OP_CRY       = 4'd11;
  localparam logic [3:0] OP_JOKE      = 4'd12;
  localparam logic [3:0] OP_NAP       = 4'd13;
  localparam logic [3:0] OP_LOVE      = 4'd14;
  localparam logic [3:0] OP_INTIMACY  = 4'd15;

  localparam logic [1:0] SL_AWAKE   = 2'd0;
  localparam logic [1:0] SL_ASLEEP  = 2'd2;
  localparam logic [1:0] TK_SCREAM  = 2'd0;
  localparam logic [1:0] TK_LAUGH   = 2'd1;
  localparam logic [1:0] TK_WHISTLE = 2'd2;
  localparam logic [1:0] TK_LISTEN  = 2'd3;
  localparam logic [1:0] DR_DRUNK   = 2'd0;
  localparam logic [1:0] DR_NORMAL  = 2'd2;
  localparam logic [1:0] AF_EAGER   = 2'd0;
  localparam logic [1:0] AF_EXCITED = 2'd1;
  localparam logic [1:0] AF_NEUTRAL = 2'd2;

  localparam logic [2:0] OC_BEG    = 3'd0;
  localparam logic [2:0] OC_MUTTER = 3'd1;
  localparam logic [2:0] OC_SNORE  = 3'd2;
  localparam logic [2:0] OC_BABBLE = 3'd3;
  localparam logic [2:0] OC_FLIRT  = 3'd4;
  localparam logic [2:0] OC_DESIRE = 3'd5;
  localparam logic [2:0] OC_INVENT = 3'd6;
  localparam logic [2:0] OC_ITCH   = 3'd7;

  typedef struct packed {
    logic [1:0] sleep;
    logic [1:0] talk;
    logic [1:0] drink;
    logic [1:0] affect;
  } mood_t;

  localparam mood_t MOOD_RESET = '{sleep: SL_ASLEEP, talk: TK_LISTEN,
                                   drink: DR_NORMAL, affect: AF_NEUTRAL};

  // One application of an opcode to the mood registers.
  function automatic mood_t mood_step(input logic [3:0] opc, input mood_t m);
    mood_t r;
    r = m;
    case (opc)
      OP_BIRTH:    r.sleep  = SL_AWAKE;
      OP_CRY:      r.talk   = TK_SCREAM;
      OP_JOKE:     r.talk   = TK_LAUGH;
      OP_LIE:      r.talk   = TK_WHISTLE;
      OP_NAP:      if (m.sleep < SL_ASLEEP) r.sleep = m.sleep + 2'd1;
      OP_DRINK:    if (m.drink != DR_DRUNK) r.drink = m.drink - 2'd1;
      OP_LOVE:     r.affect = AF_EXCITED;
      OP_INTIMACY: r.affect = AF_EAGER;
      default:     r = m;
    endcase
    return r;
  endfunction

  // {valid, code} emitted by an opcode.
  function automatic logic [3:0] emit_of(input logic [3:0] opc);
    case (opc)
      OP_REVIVE:   return {1'b1, OC_BEG};
      OP_HESITATE: return {1'b1, OC_MUTTER};
      OP_NAP:      return {1'b1, OC_SNORE};
      OP_DRINK:    return {1'b1, OC_BABBLE};
      OP_LOVE:     return {1'b1, OC_FLIRT};
      OP_INTIMACY: return {1'b1, OC_DESIRE};
      OP_PONDER:   return {1'b1, OC_INVENT};
      OP_LIE:      return {1'b1, OC_ITCH};
      default:     return 4'd0;
    endcase
  endfunction

  function automatic logic is_ctrl(input logic [3:0] opc);
    return (opc == OP_REPEAT) || (opc == OP_DICE) || (opc == OP_INTERPRET);
  endfunction

  function automatic logic [3:0] substitute(input logic [3:0] pick);
    return is_ctrl(pick) ? OP_IDLE : pick;
  endfunction
endpackage

// File: rtl/mood_lfsr.sv
`timescale 1ns/1ps
module mood_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] value
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign value = q;

  always_ff @(posedge clk) begin
    if (rst)      q <= SEED;
    else if (adv) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/mood_apply.sv
`timescale 1ns/1ps
module mood_apply
  import mood_pkg::*;
#(
  parameter int REP_BITS = 2
) (
  input  logic [3:0]        opc,
  input  mood_t             mood_in,
  input  logic [REP_BITS:0] count,
  output mood_t             mood_out
);
  localparam int DEPTH = 1 << REP_BITS;

  mood_t stage [DEPTH+1];

  assign stage[0] = mood_in;

  for (genvar k = 0; k < DEPTH; k++) begin : g_chain
    assign stage[k+1] = mood_step(opc, stage[k]);
  end

  always_comb begin
    mood_out = mood_in;
    for (int k = 1; k <= DEPTH; k++) begin
      if (count == (REP_BITS+1)'(k)) mood_out = stage[k];
    end
  end
endmodule

// File: rtl/mood_seq.sv
`timescale 1ns/1ps
module mood_seq
  import mood_pkg::*;
#(
  parameter int          PC_W     = 8,
  parameter int          REP_BITS = 2,
  parameter int          RNG_W    = 16,
  parameter logic [RNG_W-1:0] RNG_SEED = 16'hACE1,
  parameter logic [RNG_W-1:0] RNG_TAPS = 16'hB400
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op,
  input  logic            op_valid,
  output logic [1:0]      st_sleep,
  output logic [1:0]      st_talk,
  output logic [1:0]      st_drink,
  output logic [1:0]      st_affect,
  output logic [2:0]      out_code,
  output logic            out_valid,
  output logic            dead,
  output logic [PC_W-1:0] pc
);
  localparam int CNT_W = REP_BITS + 1;

  mood_t            mood_q, mood_applied;
  logic             dead_q, skip_q, interp_q;
  logic [3:0]       last_q;
  logic [PC_W-1:0]  pc_q;
  logic [2:0]       code_q;
  logic             ov_q;
  logic [RNG_W-1:0] rng;

  // named events
  logic             accept, run, rep_now, dice_now, interp_now, exec_now, fire;
  logic [3:0]       eff_op, act_op, emit;
  logic [CNT_W-1:0] rep_count, apply_count;

  assign accept     = op_valid && (!dead_q || op == OP_REVIVE);
  assign run        = accept && !skip_q;
  assign eff_op     = interp_q ? substitute(rng[3:0]) : op;
  assign rep_now    = run && (eff_op == OP_REPEAT);
  assign dice_now   = run && (eff_op == OP_DICE);
  assign interp_now = run && (eff_op == OP_INTERPRET);
  assign exec_now   = run && !is_ctrl(eff_op);
  assign fire       = rep_now || exec_now;
  assign act_op     = rep_now ? last_q : eff_op;
  assign rep_count  = {1'b0, rng[REP_BITS-1:0]} + CNT_W'(1);
  assign apply_count = rep_now ? rep_count : CNT_W'(1);
  assign emit       = emit_of(act_op);

  mood_lfsr #(.W(RNG_W), .SEED(RNG_SEED), .TAPS(RNG_TAPS)) u_rng (
    .clk   (clk),
    .rst   (rst),
    .adv   (accept),
    .value (rng)
  );

  mood_apply #(.REP_BITS(REP_BITS)) u_apply (
    .opc      (act_op),
    .mood_in  (mood_q),
    .count    (apply_count),
    .mood_out (mood_applied)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mood_q   <= MOOD_RESET;
      dead_q   <= 1'b0;
      skip_q   <= 1'b0;
      interp_q <= 1'b0;
      last_q   <= OP_IDLE;
      pc_q     <= '0;
      ov_q     <= 1'b0;
      code_q   <= '0;
    end else begin
      ov_q   <= 1'b0;
      code_q <= '0;
      if (accept) begin
        pc_q     <= pc_q + PC_W'(1);
        skip_q   <= dice_now && rng[0];
        interp_q <= interp_now;
      end
      if (fire) begin
        mood_q <= mood_applied;
        ov_q   <= emit[3];
        code_q <= emit[2:0];
        if (act_op == OP_HALT)   dead_q <= 1'b1;
        if (act_op == OP_REVIVE) dead_q <= 1'b0;
      end
      if (exec_now) last_q <= eff_op;
    end
  end

  assign st_sleep  = mood_q.sleep;
  assign st_talk   = mood_q.talk;
  assign st_drink  = mood_q.drink;
  assign st_affect = mood_q.affect;
  assign out_code  = code_q;
  assign out_valid = ov_q;
  assign dead      = dead_q;
  assign pc        = pc_q;
endmodule

// File: rtl/mood_seq_chk.sv
`timescale 1ns/1ps
module mood_seq_chk
  import mood_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int RNG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic             op_valid,
  input logic [1:0]       st_sleep,
  input logic [1:0]       st_talk,
  input logic [1:0]       st_drink,
  input logic [1:0]       st_affect,
  input logic [2:0]       out_code,
  input logic             out_valid,
  input logic             dead,
  input logic [PC_W-1:0]  pc,
  input logic             accept,
  input logic             skip_pend,
  input logic             interp_pend,
  input logic [RNG_W-1:0] rng
);
  logic [7:0] moods;
  assign moods = {st_sleep, st_talk, st_drink, st_affect};

  AST_DEAD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    dead && !(op_valid && op == OP_REVIVE) |=> dead && $stable(pc) && $stable(moods) && !out_valid); // R5
  AST_REVIVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dead && op_valid && op == OP_REVIVE |=> !dead); // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    accept |=> pc == $past(pc) + PC_W'(1)); // R7
  AST_QUIET_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(pc) && $stable(moods) && $stable(dead) && !out_valid); // R12
  AST_SKIP_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    accept && skip_pend |=> $stable(moods) && $stable(dead) && !out_valid); // R10
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    accept && !skip_pend && !interp_pend && op == OP_IDLE |=> $stable(moods) && !out_valid); // R6
  AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rng != '0); // R8
  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_code == 3'd0); // R4
endmodule

bind mood_seq mood_seq_chk #(.PC_W(PC_W), .RNG_W(RNG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op          (op),
  .op_valid    (op_valid),
  .st_sleep    (st_sleep),
  .st_talk     (st_talk),
  .st_drink    (st_drink),
  .st_affect   (st_affect),
  .out_code    (out_code),
  .out_valid   (out_valid),
  .dead        (dead),
  .pc          (pc),
  .accept      (accept),
  .skip_pend   (skip_q),
  .interp_pend (interp_q),
  .rng         (rng)
);

// File: tb/mood_seq_test.sv
`timescale 1ns/1ps
module mood_seq_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd0;
  logic       op_valid = 1'b0;
  logic [1:0] st_sleep, st_talk, st_drink, st_affect;
  logic [2:0] out_code;
  logic       out_valid, dead;
  logic [7:0] pc;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  mood_seq uut (
    .clk(clk), .rst(rst), .op(op), .op_valid(op_valid),
    .st_sleep(st_sleep), .st_talk(st_talk), .st_drink(st_drink), .st_affect(st_affect),
    .out_code(out_code), .out_valid(out_valid), .dead(dead), .pc(pc)
  );

  always #(PERIOD/2) clk = ~clk;

  // reference model, written from the requirements
  logic [1:0]  ms, mt, md, ma;
  logic        mdead, mskip, minterp, mov;
  logic [2:0]  mcode;
  logic [7:0]  mpc;
  logic [15:0] mrng;
  logic [3:0]  mlast;

  function automatic logic [15:0] rng_adv(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic m_reset();
    ms = 2; mt = 3; md = 2; ma = 2; mdead = 0; mskip = 0; minterp = 0;
    mov = 0; mcode = 0; mpc = 0; mrng = 16'hACE1; mlast = 4'd3;
  endtask

  task automatic m_effect(input logic [3:0] o);
    case (o)
      4'd0:  ms = 0;
      4'd1:  mdead = 1;
      4'd2:  begin mdead = 0; mov = 1; mcode = 0; end
      4'd6:  begin if (md != 0) md = md - 1; mov = 1; mcode = 3; end
      4'd7:  begin mov = 1; mcode = 6; end
      4'd8:  begin mov = 1; mcode = 1; end
      4'd10: begin mt = 2; mov = 1; mcode = 7; end
      4'd11: mt = 0;
      4'd12: mt = 1;
      4'd13: begin if (ms < 2) ms = ms + 1; mov = 1; mcode = 2; end
      4'd14: begin ma = 1; mov = 1; mcode = 4; end
      4'd15: begin ma = 0; mov = 1; mcode = 5; end
      default: ;
    endcase
  endtask

  task automatic m_apply(input logic [3:0] o, input logic v);
    logic [15:0] r;
    logic [3:0]  e;
    mov = 0; mcode = 0;
    if (!v) return;
    if (mdead && o != 4'd2) return;
    r = mrng;
    mrng = rng_adv(mrng);
    mpc = mpc + 1;
    if (mskip) begin mskip = 0; return; end
    if (minterp) begin
      e = (r[3:0] == 4 || r[3:0] == 5 || r[3:0] == 9) ? 4'd3 : r[3:0];
      minterp = 0;
    end else e = o;
    if (e == 4'd4) begin
      for (int k = 0; k <= int'(r[1:0]); k++) m_effect(mlast);
    end else if (e == 4'd5) mskip = r[0];
    else if (e == 4'd9) minterp = 1;
    else begin m_effect(e); mlast = e; end
  endtask

  task automatic compare(input string tag);
    logic [21:0] act, exp;
    act = {dead, pc, st_sleep, st_talk, st_drink, st_affect, out_valid, out_code};
    exp = {mdead, mpc, ms, mt, md, ma, mov, mcode};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual dead/pc/sl/tk/dr/af/ov/code=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic v, input string tag);
    @(negedge clk);
    op = o; op_valid = v;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    m_apply(o, v);
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0;
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_reset();
    compare("R1 reset");
  endtask

  task automatic t_reset();
    do_reset();
    vectors++;
    if (!(st_sleep == 2 && st_talk == 3 && st_drink == 2 && st_affect == 2 &&
          !dead && pc == 0 && !out_valid && out_code == 0)) begin
      errors++;
      $display("FAIL R1: actual %h expected sl2 tk3 dr2 af2",
               {st_sleep, st_talk, st_drink, st_affect});
    end
  endtask

  task automatic t_moods();
    do_reset();
    step(4'd0,  1, "R3 birth");
    step(4'd11, 1, "R3 cry");
    step(4'd12, 1, "R3 joke");
    step(4'd10, 1, "R3 R4 lie");
    step(4'd13, 1, "R3 nap1");
    step(4'd13, 1, "R3 nap2");
    step(4'd13, 1, "R3 nap3");
    step(4'd7,  1, "R4 ponder");
    step(4'd8,  1, "R4 hesitate");
    step(4'd14, 1, "R4 love");
    step(4'd15, 1, "R4 intimacy");
    step(4'd2,  1, "R2 R4 revive alive");
    for (int k = 0; k < 4; k++) step(4'd6, 1, "R4 drink saturate");
    vectors++;
    if (st_drink != 0) begin
      errors++;
      $display("FAIL R4: drink actual %0d expected 0", st_drink);
    end
  endtask

  task automatic t_death();
    do_reset();
    step(4'd0, 1, "R5 birth");
    step(4'd1, 1, "R5 halt");
    step(4'd11, 1, "R5 ignored cry");
    step(4'd6, 1, "R5 ignored drink");
    step(4'd4, 1, "R5 ignored repeat");
    step(4'd2, 1, "R5 revive");
    vectors++;
    if (dead !== 1'b0 || st_talk != 3) begin
      errors++;
      $display("FAIL R5: dead/talk actual %b/%0d expected 0/3", dead, st_talk);
    end
    step(4'd11, 1, "R5 alive cry");
  endtask

  task automatic t_idle_pc();
    do_reset();
    step(4'd3, 1, "R6 idle");
    step(4'd3, 1, "R6 idle");
    step(4'd11, 0, "R12 no valid");
    step(4'd6, 0, "R12 no valid");
    for (int k = 0; k < 260; k++) step(4'd3, 1, "R7 pc wrap");
  endtask

  task automatic t_repeat();
    do_reset();
    step(4'd4, 1, "R9 repeat idle after reset");
    step(4'd6, 1, "R9 drink");
    step(4'd4, 1, "R9 repeat drink");
    step(4'd0, 1, "R9 birth");
    step(4'd13, 1, "R9 nap");
    step(4'd0, 1, "R9 birth");
    step(4'd4, 1, "R9 repeat birth");
    for (int k = 0; k < 12; k++) begin
      step(4'd0, 1, "R9 birth");
      step(4'd13, 1, "R9 nap");
      step(4'd4, 1, "R9 repeat nap");
      step(4'd4, 1, "R9 repeat again");
    end
    step(4'd1, 1, "R9 halt");
    step(4'd2, 1, "R9 revive");
    step(4'd4, 1, "R9 repeat revive");
  endtask

  task automatic t_dice();
    do_reset();
    for (int k = 0; k < 24; k++) begin
      step(4'd12, 1, "R10 joke");
      step(4'd5, 1, "R10 dice");
      step(4'd11, 1, "R10 cry maybe skipped");
      step(4'd5, 1, "R10 dice");
      step(4'd1, 1, "R10 halt maybe skipped");
      if (mdead) step(4'd2, 1, "R10 revive");
    end
  endtask

  task automatic t_interp();
    do_reset();
    for (int k = 0; k < 40; k++) begin
      step(4'd9, 1, "R11 interpret");
      step(4'd3, 1, "R11 substituted");
      if (mdead) step(4'd2, 1, "R11 revive");
    end
  endtask

  task automatic t_random();
    logic [15:0] g;
    g = 16'h1D2B;
    do_reset();
    for (int k = 0; k < 400; k++) begin
      g = rng_adv(g);
      step(g[3:0], g[7:5] != 0, "R8 mixed stream");
    end
  endtask

  initial begin
    t_reset();
    t_moods();
    t_death();
    t_idle_pc();
    t_repeat();
    t_dice();
    t_interp();
    t_random();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule